// File: doc/BRIEF.md
# Flag Offset Register File

This block keeps the four byte-wide threshold registers that a FIFO uses to decide when it is almost empty and almost full. The registers are not addressed. A write pointer and a read pointer each step through the registers in a fixed cyclic order. Load writes are clocked by the write clock. Readback onto a byte-wide data output is clocked by the read clock. The two assembled 16-bit thresholds are presented continuously, ready for a flag generator to compare against. The flag comparison itself is not part of this block.

Access is possible only in programmable-threshold mode. This mode is chosen while reset is held, from the level of the load strobe. If loading stops partway, both pointers keep their positions. The next load write, or the next readback, continues at the following register.

A write and a readback attempted on the same edge is a usage error. In that case the write goes ahead, the readback is suppressed, and a sticky violation output is raised.

Top module: `flag_ofs_regfile`

## Requirements
- R1: While `rst_ni` is low, and after it rises, the outputs are in their reset state: `empty_ofs_o` equals `EMPTY_DEF` (default 16'h0107), `full_ofs_o` equals `FULL_DEF` (default 16'h0210), `q_o` is 0 and `viol_o` is 0.
- R2: Programmable mode is selected when `ld_ni` is low at the last `wr_clk_i` rising edge seen while `rst_ni` is low. If `ld_ni` was high there, load writes and readbacks have no effect on `empty_ofs_o`, `full_ofs_o` or `q_o`.
- R3: In programmable mode, a `wr_clk_i` rising edge with `ld_ni` low and `wen1_ni` low stores `d_i` into the register at the write pointer, and the pointer then advances. The slot order is: 0 = `empty_ofs_o[7:0]`, 1 = `empty_ofs_o[15:8]`, 2 = `full_ofs_o[7:0]`, 3 = `full_ofs_o[15:8]`.
- R4: Both pointers wrap. After slot 3 the next access uses slot 0.
- R5: With `ld_ni` high or `wen1_ni` high, a write edge changes no register and does not move the write pointer. Raising `ld_ni` partway through a load keeps the pointer, so the next load write goes to the following slot.
- R6: In programmable mode, a `rd_clk_i` rising edge with `ld_ni`, `ren1_ni` and `ren2_ni` all low and `wen1_ni` high loads `q_o` with the register at the read pointer, and the read pointer then advances. On any other read edge, `q_o` holds its value.
- R7: A write edge that performs a load write while `ren1_ni` and `ren2_ni` are both low still stores the data and sets `viol_o`. `viol_o` stays high until reset. A read edge with `wen1_ni` low performs no readback and does not move the read pointer.
- R8: The read and write pointers are independent. Reads do not move the write pointer, writes do not move the read pointer, and reset puts both at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Write clock; also samples the mode during reset |
| rd_clk_i | input | 1 | Read clock for readback |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ld_ni | input | 1 | Load strobe, active low; selects the mode during reset |
| wen1_ni | input | 1 | First write enable, active low |
| ren1_ni | input | 1 | First read enable, active low |
| ren2_ni | input | 1 | Second read enable, active low |
| d_i | input | 8 | Data to load into the next register |
| q_o | output | 8 | Readback data register |
| empty_ofs_o | output | 16 | Assembled almost-empty threshold |
| full_ofs_o | output | 16 | Assembled almost-full threshold |
| viol_o | output | 1 | Sticky flag for a simultaneous write and read attempt |

## Verification
A load write changes the threshold outputs directly after the write-clock edge that stores it, with one register in the path. `viol_o` also changes on that same edge. A readback changes `q_o` directly after the read-clock edge, with one register in the path.

The bench changes its inputs on the falling edge of the write clock. The read clock is 2 ns behind the write clock. The bench samples 7 ns after it drives, which is after both rising edges, so every result of a step is checked against the bench model in that same step. Each read edge always follows a write edge, and the two are mutually exclusive by their enables, so the model does not depend on the order of the edges.

// File: rtl/flag_ofs_pkg.sv
package flag_ofs_pkg;

  typedef struct packed {
    logic wr_fire;
    logic rd_req;
    logic rd_fire;
  } ofs_req_t;

  // Decode of the strobes; the write wins over a concurrent readback request
  function automatic ofs_req_t decode_req(input logic prog, input logic ld_n,
                                          input logic wen1_n, input logic ren1_n,
                                          input logic ren2_n);
    ofs_req_t r;
    r.wr_fire = prog & ~ld_n & ~wen1_n;
    r.rd_req  = prog & ~ld_n & ~ren1_n & ~ren2_n;
    r.rd_fire = r.rd_req & wen1_n;
    return r;
  endfunction

endpackage

// File: rtl/flag_ofs_seq_ptr.sv
module flag_ofs_seq_ptr #(
  parameter int unsigned NREG = 4,
  localparam int unsigned PW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [PW-1:0] ptr_o
);
  localparam logic [PW-1:0] LAST = PW'(NREG - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (adv_i) ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/flag_ofs_store.sv
module flag_ofs_store #(
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 4,
  parameter logic [NREG*DW-1:0] RST_VAL = '0,
  localparam int unsigned PW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PW-1:0]    widx_i,
  input  logic [DW-1:0]    wd_i,
  output logic [NREG*DW-1:0] regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_slot
    logic [DW-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        slot_q <= RST_VAL[g*DW +: DW];
      else if (we_i && widx_i == PW'(g))  slot_q <= wd_i;
    end
    assign regs_o[g*DW +: DW] = slot_q;
  end
endmodule

// File: rtl/flag_ofs_rd_port.sv
module flag_ofs_rd_port #(
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 4,
  localparam int unsigned PW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               re_i,
  input  logic [PW-1:0]      ridx_i,
  input  logic [NREG*DW-1:0] regs_i,
  output logic [DW-1:0]      q_o
);
  logic [DW-1:0] sel;

  always_comb sel = regs_i[int'(ridx_i)*DW +: DW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (re_i) q_o <= sel;
  end
endmodule

// File: rtl/flag_ofs_regfile.sv
module flag_ofs_regfile
  import flag_ofs_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 4,
  localparam int unsigned OW  = (NREG / 2) * DW,
  parameter logic [OW-1:0] EMPTY_DEF = OW'(16'h0107),
  parameter logic [OW-1:0] FULL_DEF  = OW'(16'h0210)
) (
  input  logic          wr_clk_i,
  input  logic          rd_clk_i,
  input  logic          rst_ni,
  input  logic          ld_ni,
  input  logic          wen1_ni,
  input  logic          ren1_ni,
  input  logic          ren2_ni,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o,
  output logic [OW-1:0] empty_ofs_o,
  output logic [OW-1:0] full_ofs_o,
  output logic          viol_o
);
  localparam int unsigned PW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [NREG*DW-1:0] RST_VAL = {FULL_DEF, EMPTY_DEF};

  logic               prog_q;
  logic [PW-1:0]      wr_ptr, rd_ptr;
  logic [NREG*DW-1:0] regs;
  ofs_req_t           req;

  // Mode follows the load strobe on write edges seen during reset; static afterwards
  always_ff @(posedge wr_clk_i) begin
    if (!rst_ni) prog_q <= ~ld_ni;
  end

  always_comb req = decode_req(prog_q, ld_ni, wen1_ni, ren1_ni, ren2_ni);

  always_ff @(posedge wr_clk_i or negedge rst_ni) begin
    if (!rst_ni)                       viol_o <= 1'b0;
    else if (req.wr_fire && req.rd_req) viol_o <= 1'b1;
  end

  flag_ofs_seq_ptr #(.NREG(NREG)) u_wr_ptr (
    .clk_i(wr_clk_i), .rst_ni(rst_ni), .adv_i(req.wr_fire), .ptr_o(wr_ptr)
  );

  flag_ofs_seq_ptr #(.NREG(NREG)) u_rd_ptr (
    .clk_i(rd_clk_i), .rst_ni(rst_ni), .adv_i(req.rd_fire), .ptr_o(rd_ptr)
  );

  flag_ofs_store #(.DW(DW), .NREG(NREG), .RST_VAL(RST_VAL)) u_store (
    .clk_i(wr_clk_i), .rst_ni(rst_ni), .we_i(req.wr_fire),
    .widx_i(wr_ptr), .wd_i(d_i), .regs_o(regs)
  );

  flag_ofs_rd_port #(.DW(DW), .NREG(NREG)) u_rd_port (
    .clk_i(rd_clk_i), .rst_ni(rst_ni), .re_i(req.rd_fire),
    .ridx_i(rd_ptr), .regs_i(regs), .q_o(q_o)
  );

  assign empty_ofs_o = regs[OW-1:0];
  assign full_ofs_o  = regs[2*OW-1:OW];
endmodule

// File: rtl/flag_ofs_regfile_chk.sv
module flag_ofs_regfile_chk #(
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 4,
  localparam int unsigned OW  = (NREG / 2) * DW,
  localparam int unsigned PW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input logic          wr_clk_i,
  input logic          rd_clk_i,
  input logic          rst_ni,
  input logic          ld_ni,
  input logic          wen1_ni,
  input logic          ren1_ni,
  input logic          ren2_ni,
  input logic          prog_i,
  input logic [PW-1:0] wr_ptr_i,
  input logic [PW-1:0] rd_ptr_i,
  input logic [DW-1:0] q_i,
  input logic [OW-1:0] empty_ofs_i,
  input logic [OW-1:0] full_ofs_i,
  input logic          viol_i
);
  logic wr_go, rd_want, rd_go;
  assign wr_go   = prog_i && !ld_ni && !wen1_ni;
  assign rd_want = prog_i && !ld_ni && !ren1_ni && !ren2_ni;
  assign rd_go   = rd_want && wen1_ni;

  AST_OFS_HOLD_NO_LOAD: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    !wr_go |=> ($stable(empty_ofs_i) && $stable(full_ofs_i)));  // R5
  AST_WR_PTR_HOLD: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    !wr_go |=> $stable(wr_ptr_i));  // R5
  AST_WR_PTR_STEP: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    (wr_go && wr_ptr_i != PW'(NREG - 1)) |=> (wr_ptr_i == PW'($past(wr_ptr_i) + PW'(1))));  // R3
  AST_WR_PTR_WRAP: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    (wr_go && wr_ptr_i == PW'(NREG - 1)) |=> (wr_ptr_i == '0));  // R4
  AST_Q_HOLD: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    !rd_go |=> $stable(q_i));  // R6
  AST_RD_BLOCKED: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (rd_want && !wen1_ni) |=> $stable(rd_ptr_i));  // R7
  AST_VIOL_SET: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    (wr_go && rd_want) |=> viol_i);  // R7
  AST_VIOL_STICKY: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    viol_i |=> viol_i);  // R7
endmodule

bind flag_ofs_regfile flag_ofs_regfile_chk #(.DW(DW), .NREG(NREG)) u_chk (
  .wr_clk_i(wr_clk_i), .rd_clk_i(rd_clk_i), .rst_ni(rst_ni),
  .ld_ni(ld_ni), .wen1_ni(wen1_ni), .ren1_ni(ren1_ni), .ren2_ni(ren2_ni),
  .prog_i(prog_q), .wr_ptr_i(wr_ptr), .rd_ptr_i(rd_ptr), .q_i(q_o),
  .empty_ofs_i(empty_ofs_o), .full_ofs_i(full_ofs_o), .viol_i(viol_o)
);

// File: tb/flag_ofs_regfile_tb_top.sv
module flag_ofs_regfile_tb_top;
  localparam logic [15:0] E_DEF = 16'h0107;
  localparam logic [15:0] F_DEF = 16'h0210;

  logic wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic ld_n = 1'b1, wen1_n = 1'b1, ren1_n = 1'b1, ren2_n = 1'b1;
  logic [7:0]  d = '0;
  logic [7:0]  q;
  logic [15:0] e_ofs, f_ofs;
  logic        viol;

  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  bit       m_prog, m_viol;
  bit [7:0] m_reg [4];
  int       m_wp, m_rp;
  bit [7:0] m_q;

  always #4 wr_clk = ~wr_clk;
  initial begin #2; forever #4 rd_clk = ~rd_clk; end

  flag_ofs_regfile dut_i (
    .wr_clk_i(wr_clk), .rd_clk_i(rd_clk), .rst_ni(rst_n), .ld_ni(ld_n),
    .wen1_ni(wen1_n), .ren1_ni(ren1_n), .ren2_ni(ren2_n), .d_i(d),
    .q_o(q), .empty_ofs_o(e_ofs), .full_ofs_o(f_ofs), .viol_o(viol)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_empty();
    return {m_reg[1], m_reg[0]};
  endfunction
  function automatic logic [15:0] exp_full();
    return {m_reg[3], m_reg[2]};
  endfunction

  task automatic check_all();
    chk("R3 empty", {16'h0, e_ofs}, {16'h0, exp_empty()});
    chk("R3 full",  {16'h0, f_ofs}, {16'h0, exp_full()});
    chk("R6 q",     {24'h0, q},     {24'h0, m_q});
    chk("R7 viol",  {31'h0, viol},  {31'h0, m_viol});
  endtask

  task automatic do_reset(input bit ld_lvl);
    @(negedge wr_clk);
    rst_n = 1'b0; ld_n = ld_lvl; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
    repeat (3) @(negedge wr_clk);
    rst_n = 1'b1; ld_n = 1'b1;
    m_prog = !ld_lvl; m_viol = 0; m_wp = 0; m_rp = 0; m_q = '0;
    m_reg[0] = E_DEF[7:0]; m_reg[1] = E_DEF[15:8];
    m_reg[2] = F_DEF[7:0]; m_reg[3] = F_DEF[15:8];
    #7;
    chk("R1 empty", {16'h0, e_ofs}, {16'h0, E_DEF});
    chk("R1 full",  {16'h0, f_ofs}, {16'h0, F_DEF});
    chk("R1 q",     {24'h0, q}, 32'h0);
    chk("R1 viol",  {31'h0, viol}, 32'h0);
  endtask

  task automatic step(input bit ld, input bit w1, input bit r1, input bit r2, input bit [7:0] dv);
    bit wf, rq, rf;
    @(negedge wr_clk);
    ld_n = ld; wen1_n = w1; ren1_n = r1; ren2_n = r2; d = dv;
    wf = m_prog && !ld && !w1;
    rq = m_prog && !ld && !r1 && !r2;
    rf = rq && w1;
    if (wf) begin
      if (rq) m_viol = 1;
      m_reg[m_wp] = dv;
      m_wp = (m_wp + 1) % 4;
    end
    if (rf) begin
      m_q = m_reg[m_rp];
      m_rp = (m_rp + 1) % 4;
    end
    #7;
    check_all();
  endtask

  task automatic wr(input bit [7:0] dv); step(0, 0, 1, 1, dv); endtask
  task automatic rd(); step(0, 1, 0, 0, 8'h00); endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h5EED_0042);

    // R1, R3, R4: load order and wrap of the write pointer
    do_reset(0);
    wr(8'hA0); wr(8'hA1); wr(8'hA2); wr(8'hA3);
    chk("R3 order empty", {16'h0, e_ofs}, 32'h0000A1A0);
    chk("R3 order full",  {16'h0, f_ofs}, 32'h0000A3A2);
    wr(8'hA4);
    chk("R4 write wrap", {16'h0, e_ofs}, 32'h0000A1A4);
    // R6, R4: readback order and read wrap
    rd(); chk("R6 read slot0", {24'h0, q}, 32'hA4);
    rd(); chk("R6 read slot1", {24'h0, q}, 32'hA1);
    rd(); rd();
    chk("R6 read slot3", {24'h0, q}, 32'hA3);
    rd(); chk("R4 read wrap", {24'h0, q}, 32'hA4);
    // R6: single read enable low does not read
    step(0, 1, 0, 1, 8'h00);
    chk("R6 partial enable hold", {24'h0, q}, 32'hA4);

    // R5, R8: partial load, pointer retention, independent pointers
    do_reset(0);
    wr(8'h11); wr(8'h22);
    step(1, 0, 1, 1, 8'hEE); step(1, 0, 1, 1, 8'hEF);
    chk("R5 ld high ignored", {16'h0, e_ofs}, 32'h00002211);
    wr(8'h33);
    chk("R5 resume slot2", {16'h0, f_ofs}, {16'h0, F_DEF[15:8], 8'h33});
    rd();
    chk("R8 read ptr from slot0", {24'h0, q}, 32'h11);
    wr(8'h44);
    chk("R8 write ptr unmoved by read", {16'h0, f_ofs}, 32'h00004433);
    // R7: collision, write wins, read suppressed
    step(0, 0, 0, 0, 8'h55);
    chk("R7 write on collision", {16'h0, e_ofs}, 32'h00002255);
    chk("R7 viol set", {31'h0, viol}, 32'h1);
    chk("R7 q held", {24'h0, q}, 32'h11);
    rd();
    chk("R7 read ptr held", {24'h0, q}, 32'h22);
    step(1, 1, 1, 1, 8'h00);
    chk("R7 viol sticky", {31'h0, viol}, 32'h1);

    // R2: non-programmable mode ignores loads and reads
    do_reset(1);
    wr(8'h99); wr(8'h98); rd(); step(0, 0, 0, 0, 8'h97);
    chk("R2 empty unchanged", {16'h0, e_ofs}, {16'h0, E_DEF});
    chk("R2 full unchanged",  {16'h0, f_ofs}, {16'h0, F_DEF});
    chk("R2 q unchanged",     {24'h0, q}, 32'h0);
    for (int i = 0; i < 40; i++)
      step($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, 8'($urandom));

    // random traffic in programmable mode (R3, R6, R7 checked every step)
    do_reset(0);
    for (int i = 0; i < 600; i++) begin
      bit ld, w1, r1, r2;
      ld = ($urandom % 10) < 3;
      w1 = $urandom % 2;
      r1 = ($urandom % 4) == 0;
      r2 = ($urandom % 4) == 0;
      step(ld, w1, r1, r2, 8'($urandom));
      if (i == 300) do_reset(0);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule